// File: doc/BRIEF.md
# Two-Wire Target Register Port for a Calendar Clock

This block is the serial-bus target side of a calendar clock. It watches the two bus lines, SCL and SDA. It finds START, repeated START and STOP conditions and answers only to its own 7-bit device address. It keeps an 8-entry byte register space. Entries 0 to 6 belong to the timekeeping counters, in the order seconds, minutes, century/hours, day, date, month and years. Entry 7 is the control byte. The block attaches no meaning to the contents. It only stores them and shows all of them on a flat output bus for the timekeeper next to it.

After a write request, the first byte sets an internal word pointer. Each later byte is stored at the pointer, and the pointer then moves on. A read streams bytes from the pointer, most significant bit first. The pointer moves on only when the master acknowledges a byte. The pointer keeps its value between transfers, so a read sent with no pointer write continues where the last access stopped.

The block never drives SDA high. It only gives a pull-low enable to an external open-drain pad. A read-activity flag tells the timekeeper to hold back its counter update while a clock entry is being streamed out.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal 1101000, with bit 0 as the direction bit: 0 selects a write (byte D0h) and 1 selects a read (byte D1h).
- R2: After an address byte with any other 7-bit address, the block gives no acknowledge. It then ignores all bytes until the next START, so neither the stored entries nor the pointer change.
- R3: In a write, the byte after the address is acknowledged and its low 3 bits load the pointer. Each later byte is acknowledged, stored at the pointer (visible on regs_o bits [8*p+7:8*p]), and then the pointer moves up by one.
- R4: The pointer wraps from 7 back to 0, both when storing and when streaming out.
- R5: After a pointer write and a repeated START with the read address, the block sends the entry at the pointer, MSB first, and keeps sending later entries.
- R6: In a read, the pointer moves on only when the master acknowledges. After a master NACK the pointer still addresses the byte that was just sent.
- R7: A read with no pointer write starts at the entry the pointer was left at by the previous access, whether that access was a read or a write.
- R8: After a master NACK the block releases SDA (sda_pull_o low) until the next START.
- R9: rd_busy_o is high from the acknowledge of a matching read address until STOP, START or a master NACK, and only while the pointer is in 0..6. It is low while the pointer is 7.
- R10: SCL or SDA pulses shorter than FILT_CYCLES clocks (10 clocks, 50 ns at 200 MHz) have no effect on the transfer.
- R11: Reset leaves sda_pull_o low, rd_busy_o low, the pointer at 0 and every entry at 00h.
- R12: The block changes sda_pull_o only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA pad |
| rd_busy_o | output | 1 | Read of a clock entry in progress; holds off the counter update |
| regs_o | output | NUM_REGS*8 | All stored entries; entry p sits in bits [8*p+7:8*p] |

## Verification
The checks assume the bus master obeys the protocol. SDA moves only while SCL is low, except at START and STOP. The master never makes a START or STOP while the block is pulling SDA low. Each SCL phase lasts longer than the two synchroniser flops plus the filter window. Under those assumptions, R12 (pull stable while SCL is high) and the filter's settle check hold. The stimulus changes each line at least 25 clocks after the other line's last edge, which is about twice the 12-clock filter latency. The only narrower pulses it makes are the deliberate 3-clock glitches of the R10 test.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } rx_ph_e;
endpackage

// File: rtl/i2c_rf_deglitch.sv
module i2c_rf_deglitch #(
    parameter int FILT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        if (q.sync[1] == q.lvl) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYCLES - 1)) begin
            d.lvl = q.sync[1];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.lvl  <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.lvl;

    // R10: the filtered level moves only after the synchronised input held steady
    p_filt_settled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl != $past(q.lvl)) |-> ($past(q.sync[1]) == $past(q.sync[1], 2)));
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [PTR_W-1:0]      wr_addr_i,
    input  logic [7:0]            wr_data_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] mem_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= 8'h00;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = mem_q[g];
    end

    // R3: a store request lands in the addressed entry one cycle later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         NUM_REGS = 8,
    parameter int         CLK_REGS = 7,
    parameter int         PTR_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [NUM_REGS*8-1:0] regs_i,
    output logic                  wr_en_o,
    output logic [PTR_W-1:0]      wr_addr_o,
    output logic [7:0]            wr_data_o,
    output logic                  pull_o,
    output logic                  busy_o
);
    localparam logic [PTR_W-1:0] LAST_CLK = PTR_W'(CLK_REGS - 1);

    typedef struct packed {
        bus_st_e          st;
        rx_ph_e           ph;
        logic [3:0]       cnt;
        logic [7:0]       shift;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             mack;
        logic             rd_act;
        logic             pull;
        logic             scl;
        logic             sda;
    } eng_t;

    eng_t q, d;
    logic rise_ev, fall_ev, start_ev, stop_ev;
    logic [PTR_W-1:0] nxt_ptr;

    assign rise_ev  = scl_i & ~q.scl;
    assign fall_ev  = ~scl_i & q.scl;
    assign start_ev = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_ev  = scl_i & q.scl & ~q.sda & sda_i;
    assign nxt_ptr  = q.ptr + 1'b1;

    always_comb begin
        d         = q;
        d.scl     = scl_i;
        d.sda     = sda_i;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = q.shift;
        if (start_ev) begin
            d.st     = ST_RX;
            d.ph     = PH_DEV;
            d.cnt    = '0;
            d.rd_act = 1'b0;
        end else if (stop_ev) begin
            d.st     = ST_IDLE;
            d.rd_act = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (rise_ev) begin
                        d.shift = {q.shift[6:0], sda_i};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (fall_ev && q.cnt == 4'd8) begin
                        d.st = ST_RX_ACK;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.shift[7:1] == DEV_ADDR) begin
                                    d.rw     = q.shift[0];
                                    d.rd_act = q.shift[0];
                                    d.ph     = PH_WORD;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_WORD: begin
                                d.ptr = q.shift[PTR_W-1:0];
                                d.ph  = PH_DATA;
                            end
                            default: begin
                                wr_en_o = 1'b1;
                                d.ptr   = nxt_ptr;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (fall_ev) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st    = ST_TX;
                            d.shift = regs_i[{q.ptr, 3'b000} +: 8];
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (fall_ev) begin
                        d.shift = {q.shift[6:0], 1'b0};
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == 4'd7) d.st = ST_TX_ACK;
                    end
                end
                ST_TX_ACK: begin
                    if (rise_ev) begin
                        d.mack = ~sda_i;
                    end else if (fall_ev) begin
                        if (q.mack) begin
                            d.ptr   = nxt_ptr;
                            d.shift = regs_i[{nxt_ptr, 3'b000} +: 8];
                            d.cnt   = '0;
                            d.st    = ST_TX;
                        end else begin
                            d.st     = ST_IDLE;
                            d.rd_act = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        d.pull = (d.st == ST_RX_ACK) || (d.st == ST_TX && !d.shift[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.scl <= 1'b1;
            q.sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pull_o = q.pull;
    assign busy_o = q.rd_act && (q.ptr <= LAST_CLK);

    // R12: no change of the SDA pull while SCL stays high
    p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && q.scl) |-> (q.pull == $past(q.pull)));
    // R6: the pointer only ever moves right after an SCL falling edge
    p_ptr_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ptr != $past(q.ptr)) |-> $past(fall_ev));
    // R3: every stored byte is followed by a pointer advance
    p_wr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (q.ptr == $past(nxt_ptr)));
    // R9: read activity begins only with the address acknowledge
    p_busy_from_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_act && !$past(q.rd_act)) |-> (q.st == ST_RX_ACK && q.pull));
    // R8: the idle target never holds SDA low
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.pull);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 8,
    parameter int         CLK_REGS    = 7,
    parameter int         FILT_CYCLES = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic                  rd_busy_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS);

    logic [1:0]       raw_lines, filt_lines;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_rf_deglitch #(.FILT_CYCLES(FILT_CYCLES)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .lvl_o (filt_lines[g])
        );
    end

    i2c_rf_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .CLK_REGS (CLK_REGS),
        .PTR_W    (PTR_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (filt_lines[1]),
        .sda_i     (filt_lines[0]),
        .regs_i    (regs_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .pull_o    (sda_pull_o),
        .busy_o    (rd_busy_o)
    );

    i2c_rf_store #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );
endmodule

// File: tb/i2c_regfile_target_tb.sv
`timescale 1ns/1ps
module i2c_regfile_target_tb;
    localparam int Q  = 25;
    localparam int NR = 8;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull, rd_busy, sda_bus;
    logic [NR*8-1:0] regs;

    assign sda_bus = m_sda & ~sda_pull;
    always #2.5 clk = ~clk;

    i2c_regfile_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .rd_busy_o(rd_busy), .regs_o(regs)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] model [NR];
    int mptr = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_byte, mon_e;
    string      mon_t;
    event       obs_ev;
    logic       a;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(logic b);
        m_scl = 0; cyc(Q); m_sda = b; cyc(Q); m_scl = 1; cyc(2*Q); m_scl = 0;
    endtask

    task automatic put_bit_g(logic b);
        m_scl = 0; cyc(Q); m_scl = 1; cyc(3); m_scl = 0; cyc(Q);
        m_sda = b; cyc(Q); m_scl = 1; cyc(Q);
        m_sda = ~b; cyc(3); m_sda = b; cyc(Q-3); m_scl = 0;
    endtask

    task automatic get_bit(output logic b);
        m_scl = 0; cyc(Q); m_sda = 1; cyc(Q); m_scl = 1; cyc(Q); b = sda_bus; cyc(Q); m_scl = 0;
    endtask

    task automatic bus_start();
        m_sda = 1; cyc(Q); m_scl = 1; cyc(Q); m_sda = 0; cyc(Q); m_scl = 0; cyc(Q);
    endtask

    task automatic bus_stop();
        m_scl = 0; cyc(Q); m_sda = 0; cyc(Q); m_scl = 1; cyc(Q); m_sda = 1; cyc(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, input bit glitch);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (glitch) put_bit_g(b[i]); else put_bit(b[i]);
        end
        get_bit(s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        obs_byte = v;
        -> obs_ev;
        put_bit(!ack);
    endtask

    // driver: pushes the expected byte, then clocks it out of the target
    task automatic rd_expect(bit ack, string tag);
        logic [7:0] v;
        exp_q.push_back(model[mptr]);
        tag_q.push_back(tag);
        recv_byte(ack, v);
        if (ack) mptr = (mptr + 1) % NR;
    endtask

    task automatic cmp_regs(string tag);
        for (int i = 0; i < NR; i++) chk(tag, $sformatf("entry %0d", i), regs[i*8 +: 8], model[i]);
    endtask

    task automatic write_regs(int ptr, input logic [7:0] dat [4], int n, bit glitch, string tag);
        logic ak;
        bus_start();
        send_byte(8'hD0, ak, 0);
        chk("R1", "write address ack", ak, 1);
        send_byte(8'(ptr), ak, glitch);
        chk("R3", "word address ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], ak, glitch);
            chk("R3", "data ack", ak, 1);
            model[(ptr + k) % NR] = dat[k];
        end
        mptr = (ptr + n) % NR;
        bus_stop();
        cmp_regs(tag);
    endtask

    // monitor: compares each byte read from the bus with the queue head
    initial forever begin
        @(obs_ev);
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 unexpected read byte: got %0h expected none", obs_byte);
        end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(mon_t, "read byte", obs_byte, mon_e);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        cyc(10);
        chk("R11", "reset pull", sda_pull, 0);
        chk("R11", "reset busy", rd_busy, 0);
        cmp_regs("R11");
        rst_n = 1;
        cyc(30);

        // R3: plain write from entry 0
        write_regs(0, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, 0, "R3");
        // R4: write wraps past entry 7
        write_regs(6, '{8'hA6, 8'hA7, 8'hB0, 8'h00}, 3, 0, "R4");

        // R5/R6/R8: random read from 0, ack, ack, nack
        bus_start();
        send_byte(8'hD0, a, 0); chk("R1", "write address ack", a, 1);
        send_byte(8'h00, a, 0); chk("R5", "word address ack", a, 1);
        mptr = 0;
        bus_start();
        send_byte(8'hD1, a, 0); chk("R1", "read address ack", a, 1);
        cyc(20); chk("R9", "busy after read ack", rd_busy, 1);
        rd_expect(1, "R5");
        rd_expect(1, "R5");
        rd_expect(0, "R6");
        cyc(20);
        chk("R8", "pull after nack", sda_pull, 0);
        chk("R9", "busy after nack", rd_busy, 0);
        bus_stop();

        // R6/R7: read without pointer write resumes at NACKed entry 2
        bus_start();
        send_byte(8'hD1, a, 0); chk("R1", "read address ack", a, 1);
        rd_expect(0, "R7");
        bus_stop();

        // R2: foreign address is ignored until next START
        bus_start();
        send_byte(8'hA0, a, 0); chk("R2", "foreign address no ack", a, 0);
        send_byte(8'h02, a, 0); chk("R2", "ignored byte no ack", a, 0);
        send_byte(8'h5A, a, 0); chk("R2", "ignored byte no ack", a, 0);
        bus_stop();
        cmp_regs("R2");
        bus_start();
        send_byte(8'hD1, a, 0); chk("R1", "read address ack", a, 1);
        rd_expect(0, "R2");
        bus_stop();

        // R9/R4: busy window around entry 7 and read wrap
        write_regs(5, '{8'h55, 8'h66, 8'h00, 8'h00}, 2, 0, "R3");
        bus_start();
        send_byte(8'hD0, a, 0); chk("R1", "write address ack", a, 1);
        send_byte(8'h05, a, 0); chk("R3", "word address ack", a, 1);
        mptr = 5;
        bus_start();
        send_byte(8'hD1, a, 0); chk("R1", "read address ack", a, 1);
        cyc(20); chk("R9", "busy at entry 5", rd_busy, 1);
        rd_expect(1, "R9");
        cyc(20); chk("R9", "busy at entry 6", rd_busy, 1);
        rd_expect(1, "R9");
        cyc(20); chk("R9", "busy at entry 7", rd_busy, 0);
        rd_expect(1, "R4");
        cyc(20); chk("R9", "busy after wrap to 0", rd_busy, 1);
        rd_expect(0, "R4");
        cyc(20); chk("R9", "busy after nack", rd_busy, 0);
        bus_stop();

        // R10: short glitches on both lines during every bit
        write_regs(4, '{8'hC3, 8'h3C, 8'h00, 8'h00}, 2, 1, "R10");

        // R7: read resumes after a write at entry 6
        bus_start();
        send_byte(8'hD1, a, 0); chk("R1", "read address ack", a, 1);
        rd_expect(0, "R7");
        bus_stop();

        cyc(50);
        chk("R5", "pending reads", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule